// File: doc/BRIEF.md
# Interrupt Moderation Timer Pair

This block sits between a completion source (one transfer direction, receive or transmit) and the interrupt line, and it merges bursts of completion events into fewer interrupts. Two counters cooperate. A burst counter starts with the first event of a pending batch and bounds how long that event may wait. An idle counter starts again on every event and fires once the stream has been quiet for its threshold. Whichever reaches its threshold first raises a one-cycle moderated interrupt, and both counters then return to rest.

Each counter can step on every clock or only on an external microsecond tick, so a threshold is either a cycle count or a time in microseconds. Software configures a counter in a fixed order: it writes the control word with only the clear bit, then the threshold, then the enable together with the tick choice. If either counter is not enabled, every event is forwarded as an interrupt without delay. A chip with both directions uses one instance per direction.

Top module: `irq_moderator`

## Requirements
- R1: After reset the interrupt output is low and both control words are zero, so neither counter is enabled.
- R2: While either counter is not enabled, the interrupt output is high for exactly the cycle after each cycle in which the event input is high.
- R3: With both counters enabled and nonzero thresholds, the interrupt rises a burst-threshold number of steps after the first event of a pending batch, however many events follow it.
- R4: With both counters enabled and nonzero thresholds, the interrupt rises an idle-threshold number of steps after the latest event when no further event arrives in that span, if that comes before the burst limit.
- R5: The moderated interrupt is a single-cycle pulse; both counters and the pending state are cleared with it, so the next event opens a new batch timed from that event.
- R6: A threshold of zero on either enabled counter makes the interrupt rise in the cycle after the event itself.
- R7: With the tick-select bit set, a counter advances only in cycles where the microsecond tick input is high; with it clear, it advances every cycle.
- R8: A control word with the clear bit set stops and zeroes that counter and drops any pending batch, even when the enable bit is also set; a batch pending before the clear never produces an interrupt.
- R9: Register writes use address 0 for the burst control word, 1 for the burst threshold, 2 for the idle control word and 3 for the idle threshold; control bit 0 is clear, bit 1 is enable, bit 2 is tick select; thresholds take the low CNT_W data bits. A write takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Completion event, one cycle per completion |
| us_tick_i | input | 1 | Microsecond tick, one cycle per microsecond |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register address |
| wr_data_i | input | DW | Register write data |
| irq_o | output | 1 | Moderated interrupt pulse |

## Verification
The bench goes after the race between the two limits: a steady stream where only the burst limit may end the batch (a design that restarts the burst count on every event would never interrupt), and spaced events exactly at the idle threshold (an off-by-one compare would fire early between events). It also tests zero thresholds, where a design that needs one step first would delay by a cycle, and a batch left pending across a clear, which a design that keeps stale pending state would later report. Tick-mode counting and back-to-back batches after a fire check that a design counting clocks in tick mode, or keeping counts across a fire, shows the wrong latency.

// File: rtl/irq_moderator.sv
module irq_moderator #(
  parameter int DW    = 32,
  parameter int AW    = 2,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic          us_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          irq_o
);

  localparam int CLR  = 0;
  localparam int EN   = 1;
  localparam int TSEL = 2;
  localparam logic [AW-1:0] A_BCTL = AW'(0);
  localparam logic [AW-1:0] A_BTHR = AW'(1);
  localparam logic [AW-1:0] A_ICTL = AW'(2);
  localparam logic [AW-1:0] A_ITHR = AW'(3);

  logic [2:0]       b_ctl, i_ctl;
  logic [CNT_W-1:0] b_thr, i_thr, b_cnt, i_cnt;
  logic             pend, irq_q;

  wire b_on   = b_ctl[EN] & ~b_ctl[CLR];
  wire i_on   = i_ctl[EN] & ~i_ctl[CLR];
  wire mod_on = b_on & i_on;
  wire b_step = b_ctl[TSEL] ? us_tick_i : 1'b1;
  wire i_step = i_ctl[TSEL] ? us_tick_i : 1'b1;
  wire active = pend | evt_i;

  wire [CNT_W:0] b_nxt = pend ? ({1'b0, b_cnt} + (CNT_W+1)'(b_step)) : '0;
  wire [CNT_W:0] i_nxt = (evt_i || !pend) ? '0 : ({1'b0, i_cnt} + (CNT_W+1)'(i_step));

  wire fire = mod_on & active &
              ((b_nxt >= {1'b0, b_thr}) | (i_nxt >= {1'b0, i_thr}));

  assign irq_o = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_ctl <= '0;
      i_ctl <= '0;
      b_thr <= '0;
      i_thr <= '0;
      b_cnt <= '0;
      i_cnt <= '0;
      pend  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          A_BCTL:  b_ctl <= wr_data_i[2:0];
          A_BTHR:  b_thr <= wr_data_i[CNT_W-1:0];
          A_ICTL:  i_ctl <= wr_data_i[2:0];
          A_ITHR:  i_thr <= wr_data_i[CNT_W-1:0];
          default: ;
        endcase
      end
      if (!mod_on) begin
        pend  <= 1'b0;
        b_cnt <= '0;
        i_cnt <= '0;
        irq_q <= evt_i;
      end else if (fire) begin
        pend  <= 1'b0;
        b_cnt <= '0;
        i_cnt <= '0;
        irq_q <= 1'b1;
      end else begin
        irq_q <= 1'b0;
        if (active) begin
          pend  <= 1'b1;
          b_cnt <= b_nxt[CNT_W-1:0];
          i_cnt <= i_nxt[CNT_W-1:0];
        end
      end
    end
  end

  // R2
  cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(evt_i) || $past(pend)));

  // R3
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $stable(b_thr)) |-> (b_cnt < b_thr));

  // R4
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $stable(i_thr)) |-> (i_cnt < i_thr));

  // R5
  fire_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !pend);

  // R7
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && mod_on && b_ctl[TSEL] && !us_tick_i) |=> ((b_cnt == $past(b_cnt)) || !pend));

  // R8
  off_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_on |=> !pend);

endmodule

// File: tb/sim_irq_moderator.sv
module sim_irq_moderator;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam int CNT_W = 16;
  localparam int NV = 9;
  // burst thr, idle thr, event gap, event count
  localparam int VEC [NV][4] = '{
    '{8, 3, 1, 20}, '{20, 4, 2, 5}, '{20, 4, 6, 3},
    '{10, 10, 1, 1}, '{0, 5, 1, 3}, '{6, 0, 1, 3},
    '{5, 5, 5, 4}, '{30, 7, 7, 3}, '{1, 9, 1, 4}};

  logic clk = 0, rst_n = 0, evt = 0, tick = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic irq;
  int total = 0, bad = 0;

  irq_moderator #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .us_tick_i(tick),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .irq_o(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  // R9: ctrl bit0 clear, bit1 enable, bit2 tick select
  task automatic cfg(input int b, input int i, input int bsel, input int isel);
    wr(0, 1); wr(1, b); wr(0, 2 | (bsel << 2));
    wr(2, 1); wr(3, i); wr(2, 2 | (isel << 2));
  endtask

  task automatic stim(input int g, input int n, input int tp, input int to,
                      input int limit, output int lat, output int cnt);
    lat = -1; cnt = 0;
    for (int c = 0; c < limit; c++) begin
      evt  = (c % g == 0) && (c / g < n);
      tick = (tp > 0) && (c % tp == to);
      @(posedge clk);
      @(negedge clk);
      if (irq) begin
        cnt++;
        if (lat < 0) lat = c;
      end
    end
    evt = 0; tick = 0;
  endtask

  function automatic int exp_lat(input int b, input int i, input int g, input int n);
    int idle;
    if (b == 0 || i == 0) return 0;
    idle = (n > 1 && g <= i) ? (n - 1) * g + i : i;
    return (b < idle) ? b : idle;
  endfunction

  initial begin
    #(20 * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, cnt;
    repeat (3) @(negedge clk);
    chk("R1 irq low in reset", int'(irq), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq low after reset", int'(irq), 0);

    // R1 R2: defaults leave moderation off, events pass through
    stim(3, 3, 0, 0, 9, lat, cnt);
    chk("R2 passthrough count", cnt, 3);
    chk("R2 passthrough latency", lat, 0);

    // R3 R4 R6: vector table
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v][0], VEC[v][1], 0, 0);
      stim(VEC[v][2], VEC[v][3], 0, 0, 60, lat, cnt);
      chk($sformatf("R3/R4/R6 vector %0d latency", v), lat,
          exp_lat(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]));
    end

    // R5: two batches, single-cycle pulses, fresh timing
    cfg(6, 50, 0, 0);
    stim(8, 2, 0, 0, 40, lat, cnt);
    chk("R5 first batch latency", lat, 6);
    chk("R5 one pulse per batch", cnt, 2);

    // R7: burst in tick mode, ticks at cycles 2,6,10
    cfg(3, 100, 1, 0);
    stim(1, 1, 4, 2, 40, lat, cnt);
    chk("R7 tick mode latency", lat, 10);
    chk("R7 tick mode pulses", cnt, 1);

    // R7: idle in tick mode, ticks every 3 cycles at 1,4
    cfg(100, 2, 0, 1);
    stim(1, 1, 3, 1, 30, lat, cnt);
    chk("R7 idle tick latency", lat, 4);

    // R8: pending batch dropped by clear
    cfg(10, 10, 0, 0);
    stim(1, 1, 0, 0, 3, lat, cnt);
    chk("R8 no early irq", cnt, 0);
    wr(0, 1);
    wr(0, 2);
    stim(1, 0, 0, 0, 30, lat, cnt);
    chk("R8 stale batch dropped", cnt, 0);
    stim(1, 1, 0, 0, 30, lat, cnt);
    chk("R8 R5 fresh batch after clear", lat, 10);

    // R8: clear dominates enable -> passthrough
    wr(0, 3);
    stim(1, 4, 0, 0, 6, lat, cnt);
    chk("R8 clear with enable passes through", cnt, 4);

    // R2: only burst enabled, idle disabled
    cfg(10, 10, 0, 0);
    wr(2, 0);
    stim(2, 3, 0, 0, 7, lat, cnt);
    chk("R2 idle off passthrough count", cnt, 3);
    chk("R2 idle off passthrough latency", lat, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule